// File: doc/BRIEF.md
# Dual-Bank IN Endpoint Controller

This block runs the transmit side of a single device IN endpoint with two payload banks that take turns. Firmware writes bytes into whichever bank it currently owns, then hands that bank over with a byte count by asserting a ready strobe. Ownership of the fill side then moves to the other bank, so the next payload can be prepared while the first one waits for, or is already on, the bus.

The bus side is an abstract token/handshake interface. An IN token either starts streaming the oldest ready bank, one byte per cycle, or is answered with a NAK pulse when nothing is ready. When the host acknowledges, that bank goes back to firmware, the send side moves to the other bank, and a sticky transmit-complete flag is raised, which also drives the interrupt line. A missing acknowledgement leaves the bank ready for a retry. Packet identifiers, CRC, bit stuffing and line coding are handled elsewhere.

Top module: `dual_bank_in_ep`

## Requirements
- R1: After synchronous reset, fw_fill_bank is 0, txc and irq are 0, tx_valid, tx_zlp and tx_nak are 0, and no bank is ready, so the first IN token is answered with NAK.
- R2: A write is stored at fw_wr_addr of the bank shown on fw_fill_bank. fw_ready_set marks that bank ready, latches its count, and flips fw_fill_bank (0 to 1, 1 to 0) on the following cycle.
- R3: An IN token that arrives while the send bank is ready with count N>0 makes tx_valid high for exactly N consecutive cycles, starting the cycle after the token. tx_data carries bytes at addresses 0..N-1 in order, tx_bank shows the bank number, and tx_last is high only on the final byte.
- R4: An IN token that arrives with the send bank not ready gives a one-cycle tx_nak in the following cycle and no data.
- R5: A ready bank with count 0 answers an IN token with a one-cycle tx_zlp in the following cycle and no tx_valid. It then waits for a handshake like any other packet.
- R6: A requested count above 64 is saturated to 64 bytes.
- R7: host_ack while a packet awaits its handshake releases the sent bank, moves sending to the other bank and sets txc. irq always equals txc.
- R8: txc stays set until fw_txc_clr. If host_ack and fw_txc_clr coincide, txc ends set.
- R9: host_timeout while awaiting the handshake leaves the bank ready and txc unchanged. The next IN token resends the identical payload from the same bank.
- R10: Banks are sent strictly in the order 0, 1, 0, 1, matching the order in which they were filled.
- R11: While the bank on fw_fill_bank is still ready (both banks full), writes and fw_ready_set are ignored. fw_fill_bank does not change and the pending payload is later sent unaltered.
- R12: IN tokens during streaming or during the handshake wait are ignored (no NAK, no restart). host_ack and host_timeout outside the handshake wait are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_addr | input | 6 | Byte address inside the fill bank |
| fw_wr_data | input | 8 | Byte to store |
| fw_ready_set | input | 1 | Hand the fill bank to the bus side |
| fw_ready_cnt | input | 7 | Payload length latched with fw_ready_set |
| fw_txc_clr | input | 1 | Clear transmit-complete |
| fw_fill_bank | output | 1 | Bank currently owned by firmware |
| in_token | input | 1 | IN token received, one-cycle pulse |
| host_ack | input | 1 | Host acknowledged the last packet |
| host_timeout | input | 1 | Handshake did not arrive |
| tx_valid | output | 1 | Payload byte valid |
| tx_data | output | 8 | Payload byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_bank | output | 1 | Bank being streamed |
| tx_zlp | output | 1 | Zero-length packet sent |
| tx_nak | output | 1 | NAK answered |
| txc | output | 1 | Transmit-complete flag |
| irq | output | 1 | Endpoint interrupt pending |

## Verification
The hardest state to reach is both banks full with the fill pointer resting on a bank that the bus side has not yet released. Reaching it takes two loads and a third attempt with no acknowledgement in between. The stimulus then has to show that the blocked write left the payload intact, and that only acknowledgements free the banks, in strict turn. The bench loads both banks, tries a third load, and then drives timeout, retry and acknowledge sequences. A byte scoreboard checks every streamed byte against the bank contents the firmware actually got to keep.

// File: rtl/dbin_pkg.sv
package dbin_pkg;
    localparam int DEPTH = 64;
    localparam int DW    = 8;
    localparam int NB    = 2;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic          rdy;
        logic [CW-1:0] cnt;
    } bank_ctl_t;

    function automatic logic [CW-1:0] sat_count(input logic [CW-1:0] req);
        return (req > CW'(DEPTH)) ? CW'(DEPTH) : req;
    endfunction
endpackage

// File: rtl/dbin_bank_mem.sv
module dbin_bank_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int NB    = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [BW-1:0] rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] rd_vec [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_bank == BW'(b))
                mem[wr_addr] <= wr_data;
        end
        assign rd_vec[b] = mem[rd_addr];
    end

    assign rd_data = rd_vec[rd_bank];
endmodule

// File: rtl/dbin_bank_state.sv
module dbin_bank_state
    import dbin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_ready_set,
    input  logic [CW-1:0] fw_ready_cnt,
    input  logic          fw_txc_clr,
    input  logic          ack_done,
    output logic          fill_ptr,
    output logic          fill_busy,
    output logic          send_ptr,
    output logic          send_rdy,
    output logic [CW-1:0] send_cnt,
    output logic          txc
);
    bank_ctl_t ctl [NB];
    logic      set_ok;

    assign fill_busy = ctl[fill_ptr].rdy;
    assign set_ok    = fw_ready_set && !fill_busy;
    assign send_rdy  = ctl[send_ptr].rdy;
    assign send_cnt  = ctl[send_ptr].cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) ctl[b] <= '0;
            fill_ptr <= 1'b0;
            send_ptr <= 1'b0;
            txc      <= 1'b0;
        end else begin
            if (set_ok) begin
                ctl[fill_ptr].rdy <= 1'b1;
                ctl[fill_ptr].cnt <= sat_count(fw_ready_cnt);
                fill_ptr          <= ~fill_ptr;
            end
            if (ack_done) begin
                ctl[send_ptr].rdy <= 1'b0;
                send_ptr          <= ~send_ptr;
            end
            if (ack_done)        txc <= 1'b1;
            else if (fw_txc_clr) txc <= 1'b0;
        end
    end

    AST_FULL_ORDER: assert property (@(posedge clk) disable iff (rst)
        (ctl[0].rdy && ctl[1].rdy) |-> (fill_ptr == send_ptr)); // R10
    AST_ACK_ON_READY: assert property (@(posedge clk) disable iff (rst)
        ack_done |-> send_rdy); // R7
    AST_TXC_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        ack_done |=> txc); // R7
    AST_TXC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (txc && !fw_txc_clr) |=> txc); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        send_cnt <= CW'(DEPTH)); // R6
endmodule

// File: rtl/dbin_tx_fsm.sv
module dbin_tx_fsm
    import dbin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_token,
    input  logic          host_ack,
    input  logic          host_timeout,
    input  logic          send_rdy,
    input  logic [CW-1:0] send_cnt,
    output logic [AW-1:0] rd_addr,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          tx_nak,
    output logic          tx_zlp,
    output logic          ack_done
);
    tx_state_e     state;
    logic [AW-1:0] idx;

    assign rd_addr  = idx;
    assign tx_valid = (state == ST_SEND);
    assign tx_last  = tx_valid && (CW'(idx) == send_cnt - CW'(1));
    assign ack_done = (state == ST_WAIT) && host_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            tx_nak <= 1'b0;
            tx_zlp <= 1'b0;
        end else begin
            tx_nak <= 1'b0;
            tx_zlp <= 1'b0;
            case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (in_token) begin
                        if (!send_rdy) begin
                            tx_nak <= 1'b1;
                        end else if (send_cnt == '0) begin
                            tx_zlp <= 1'b1;
                            state  <= ST_WAIT;
                        end else begin
                            state <= ST_SEND;
                        end
                    end
                end
                ST_SEND: begin
                    if (tx_last) state <= ST_WAIT;
                    else         idx   <= idx + AW'(1);
                end
                ST_WAIT: begin
                    if (host_ack || host_timeout) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_NAK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_nak |-> ($past(in_token) && !$past(send_rdy))); // R4
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_nak, tx_zlp, tx_valid})); // R5
    AST_STREAM_READY: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> send_rdy); // R3
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_last) |=> !tx_valid); // R3
endmodule

// File: rtl/dual_bank_in_ep.sv
module dual_bank_in_ep
    import dbin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_wr_en,
    input  logic [AW-1:0] fw_wr_addr,
    input  logic [DW-1:0] fw_wr_data,
    input  logic          fw_ready_set,
    input  logic [CW-1:0] fw_ready_cnt,
    input  logic          fw_txc_clr,
    output logic          fw_fill_bank,
    input  logic          in_token,
    input  logic          host_ack,
    input  logic          host_timeout,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    output logic          tx_bank,
    output logic          tx_zlp,
    output logic          tx_nak,
    output logic          txc,
    output logic          irq
);
    logic          fill_busy, send_ptr, send_rdy, ack_done;
    logic [CW-1:0] send_cnt;
    logic [AW-1:0] rd_addr;

    dbin_bank_state u_state (
        .clk(clk), .rst(rst),
        .fw_ready_set(fw_ready_set), .fw_ready_cnt(fw_ready_cnt),
        .fw_txc_clr(fw_txc_clr), .ack_done(ack_done),
        .fill_ptr(fw_fill_bank), .fill_busy(fill_busy),
        .send_ptr(send_ptr), .send_rdy(send_rdy),
        .send_cnt(send_cnt), .txc(txc)
    );

    dbin_bank_mem #(.DEPTH(DEPTH), .DW(DW), .NB(NB)) u_mem (
        .clk(clk),
        .wr_en(fw_wr_en && !fill_busy), .wr_bank(fw_fill_bank),
        .wr_addr(fw_wr_addr), .wr_data(fw_wr_data),
        .rd_bank(send_ptr), .rd_addr(rd_addr), .rd_data(tx_data)
    );

    dbin_tx_fsm u_fsm (
        .clk(clk), .rst(rst),
        .in_token(in_token), .host_ack(host_ack), .host_timeout(host_timeout),
        .send_rdy(send_rdy), .send_cnt(send_cnt), .rd_addr(rd_addr),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_nak(tx_nak),
        .tx_zlp(tx_zlp), .ack_done(ack_done)
    );

    assign tx_bank = send_ptr;
    assign irq     = txc;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        irq == txc); // R7
    AST_FULL_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        fill_busy |=> $stable(fw_fill_bank)); // R11
endmodule

// File: tb/sim_dual_bank_in_ep.sv
module sim_dual_bank_in_ep;
    logic       clk = 1'b0;
    logic       rst;
    logic       fw_wr_en, fw_ready_set, fw_txc_clr;
    logic [5:0] fw_wr_addr;
    logic [7:0] fw_wr_data;
    logic [6:0] fw_ready_cnt;
    logic       fw_fill_bank;
    logic       in_token, host_ack, host_timeout;
    logic       tx_valid, tx_last, tx_bank, tx_zlp, tx_nak, txc, irq;
    logic [7:0] tx_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [9:0] expq [$];
    logic [7:0] mdat [2][64];
    int         mcnt [2];
    bit         mrdy [2];
    bit         mf, ms, mtxc, mwait;

    always #5 clk = ~clk;

    dual_bank_in_ep u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            if (expq.size() == 0) begin
                chk(0, "R3 unexpected byte", int'({tx_bank, tx_last, tx_data}), 0);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                chk({tx_bank, tx_last, tx_data} == e, "R3/R10 byte",
                    int'({tx_bank, tx_last, tx_data}), int'(e));
            end
        end
    end

    task automatic load(input logic [7:0] seed, input int req);
        int n;
        bit ok;
        n = (req > 64) ? 64 : req;
        ok = !mrdy[mf];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fw_wr_en = 1; fw_wr_addr = 6'(i); fw_wr_data = seed + 8'(i);
            if (ok) mdat[mf][i] = seed + 8'(i);
        end
        @(negedge clk);
        fw_wr_en = 0; fw_ready_set = 1; fw_ready_cnt = 7'(req);
        @(negedge clk);
        fw_ready_set = 0;
        if (ok) begin
            mrdy[mf] = 1; mcnt[mf] = n; mf = ~mf;
        end
        chk(fw_fill_bank == mf, ok ? "R2 fill bank" : "R11 fill bank held",
            int'(fw_fill_bank), int'(mf));
    endtask

    task automatic token(input bit poke);
        bit nak_e, zlp_e;
        int n;
        nak_e = !mrdy[ms];
        zlp_e = mrdy[ms] && mcnt[ms] == 0;
        n = nak_e ? 0 : mcnt[ms];
        if (!nak_e) begin
            for (int i = 0; i < n; i++)
                expq.push_back({ms, (i == n - 1), mdat[ms][i]});
            mwait = 1;
        end
        @(negedge clk);
        in_token = 1;
        @(negedge clk);
        in_token = 0;
        chk(tx_nak == nak_e, "R4 nak", int'(tx_nak), int'(nak_e));
        chk(tx_zlp == zlp_e, "R5 zlp", int'(tx_zlp), int'(zlp_e));
        for (int i = 0; i < n + 1; i++) begin
            @(negedge clk);
            if (poke && i == 0) in_token = 1;
            else in_token = 0;
            chk(!tx_nak && !tx_zlp, "R12 no answer mid-packet",
                int'({tx_nak, tx_zlp}), 0);
        end
        in_token = 0;
        #1;
        chk(expq.size() == 0, "R3 packet length", expq.size(), 0);
    endtask

    task automatic hs(input bit ack, input bit tmo, input bit clr);
        @(negedge clk);
        host_ack = ack; host_timeout = tmo; fw_txc_clr = clr;
        if (mwait && ack) begin
            mrdy[ms] = 0; ms = ~ms; mtxc = 1; mwait = 0;
        end else begin
            if (clr) mtxc = 0;
            if (tmo) mwait = 0;
        end
        @(negedge clk);
        host_ack = 0; host_timeout = 0; fw_txc_clr = 0;
        chk(txc == mtxc, "R7/R8 txc", int'(txc), int'(mtxc));
        chk(irq == txc, "R7 irq", int'(irq), int'(txc));
    endtask

    initial begin
        rst = 1; fw_wr_en = 0; fw_ready_set = 0; fw_txc_clr = 0;
        fw_wr_addr = 0; fw_wr_data = 0; fw_ready_cnt = 0;
        in_token = 0; host_ack = 0; host_timeout = 0;
        mf = 0; ms = 0; mtxc = 0; mwait = 0;
        mrdy[0] = 0; mrdy[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(fw_fill_bank == 0, "R1 fill bank", int'(fw_fill_bank), 0);
        chk({txc, irq, tx_valid, tx_zlp, tx_nak} == 0, "R1 outputs",
            int'({txc, irq, tx_valid, tx_zlp, tx_nak}), 0);
        token(0);                 // R1 R4: nothing ready -> NAK
        hs(1, 0, 0);              // R12: ack while idle ignored
        hs(0, 1, 0);              // R12: timeout while idle ignored
        load(8'h10, 5);           // R2 bank 0
        load(8'h40, 3);           // R2 bank 1
        load(8'h80, 4);           // R11 both full: ignored
        token(0);                 // R3 R10 bank 0
        hs(0, 1, 0);              // R9 timeout
        token(1);                 // R9 resend, R12 poke mid-stream
        hs(1, 0, 0);              // R7
        hs(0, 0, 1);              // R8 clear
        load(8'hA0, 70);          // R6 saturate into bank 0
        token(0);                 // R10 bank 1 (unaltered, R11)
        hs(1, 0, 1);              // R8 ack wins over clear
        token(0);                 // R6 64 bytes from bank 0
        hs(1, 0, 0);
        load(8'h00, 0);           // R5 zero-length in bank 1
        token(0);                 // R5 zlp
        hs(1, 0, 0);
        token(0);                 // R4 none ready
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule